// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits on the output data path of a multi-bit converter and, when a test mode is selected, replaces the converted samples with a known 14-bit word. A 4-bit mode field chooses among fixed levels, word and bit toggles, a sync word, a mixed-frequency word, two pseudorandom generators (a long 23-stage one and a short 9-stage one), and a player for two user-supplied words. When the mode is off, the normal data passes through unchanged.

The output is a register that loads once per valid sample, one clock after the sample-valid strobe. Both pseudorandom generators step on every valid sample, whatever the mode. Each generator can be reseeded by its own clear pulse. The user-word player can repeat one word, alternate two words, or play either choice a single time and then hold zero. A change of the mode field restarts every toggle and the player. In user mode, a change of the playback control also restarts them.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: After the synchronous active-low reset, `data_o` is 0x0000. Both pseudorandom shift registers hold all ones.
- R2: With mode 0000, a valid sample loads `data_i` into `data_o` on the next clock edge.
- R3: Mode codes 1101, 1110 and 1111 behave exactly like mode 0000.
- R4: The fixed words are: 0001 gives 0x2000, 0010 gives 0x3FFF, 0011 gives 0x0000, 1001 gives 0x2AAA, 1010 gives 0x007F, 1011 gives 0x2000 and 1100 gives 0x2863.
- R5: Mode 0100 alternates 0x2AAA and 0x1555 on successive valid samples. Mode 0111 alternates 0x3FFF and 0x0000. The first valid sample after a change of mode gives the first word of each pair.
- R6: `data_o` changes only on a clock edge that follows a cycle with `sample_vld_i` high. In every other cycle it holds.
- R7: Mode 0101 outputs bits [13:0] of a 23-bit shift register. On each valid sample the register shifts left by one bit and takes bit22 XOR bit17 into bit0 (x^23+x^18+1). The output word is the register value after that step.
- R8: Mode 0110 outputs bits [13:0] of a 14-bit shift register. On each valid sample the register shifts left by one bit and takes bit8 XOR bit4 into bit0 (x^9+x^5+1).
- R9: A high `pn_long_clr_i` sets the 23-bit register to all ones in place of a step. If a valid sample falls in the same cycle in mode 0101, the output is 0x3FFF. The 14-bit register is not affected.
- R10: A high `pn_short_clr_i` does the same for the 14-bit register and leaves the 23-bit register unaffected.
- R11: In mode 1000 the playback control selects the words. Code 00 outputs `user_word0_i` on every sample. Code 01 alternates `user_word0_i` and `user_word1_i`, starting with word 0.
- R12: Code 10 outputs word 0 once and then 0x0000. Code 11 outputs word 0, then word 1, then 0x0000. Either sequence starts again after a change of the mode field or of the playback control.
- R13: Outside mode 1000 the playback control has no effect. Changing it does not restart the toggle sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 4 | Test mode select |
| user_ctl_i | input | 2 | User playback control, bit1 = once, bit0 = alternate |
| user_word0_i | input | 14 | First user word |
| user_word1_i | input | 14 | Second user word |
| pn_long_clr_i | input | 1 | Reseed pulse for the 23-stage generator |
| pn_short_clr_i | input | 1 | Reseed pulse for the 9-stage generator |
| sample_vld_i | input | 1 | Sample valid strobe |
| data_i | input | 14 | Normal converter data |
| data_o | output | 14 | Selected output word |

## Verification
Every result appears on `data_o` exactly one clock after the cycle that presents the sample. A cycle without the valid strobe must leave the previous word in place. The driver task tags each expected word with the cycle count at which it becomes due. The monitor compares only at the falling edge of that cycle, so the settled register is sampled away from the update edge. The bench keeps its own models of the shift registers, the toggle phase and the player position. It advances them once per driven cycle, so pseudorandom words, restarts and once-only tails line up with the same one-cycle latency.

// File: rtl/tpg_pkg.sv
// Package: shared mode codes, word width and fixed pattern words
// for the output test pattern generator.
package tpg_pkg;

    localparam int TPG_W = 14;

    typedef enum logic [3:0] {
        TM_OFF      = 4'h0,
        TM_MID      = 4'h1,
        TM_POSFS    = 4'h2,
        TM_NEGFS    = 4'h3,
        TM_CHECKER  = 4'h4,
        TM_PN_LONG  = 4'h5,
        TM_PN_SHORT = 4'h6,
        TM_WORD_TGL = 4'h7,
        TM_USER     = 4'h8,
        TM_BIT_TGL  = 4'h9,
        TM_SYNC     = 4'hA,
        TM_ONE_HIGH = 4'hB,
        TM_MIXED    = 4'hC
    } tp_mode_e;

    // Alternating bit word; msb_set picks which phase owns the MSB.
    function automatic logic [TPG_W-1:0] alt_bits(input logic msb_set);
        logic [TPG_W-1:0] b;
        for (int i = 0; i < TPG_W; i++) begin
            b[i] = ((((TPG_W - 1 - i) % 2) == 0) == msb_set);
        end
        return b;
    endfunction

    localparam logic [TPG_W-1:0] W_MID   = TPG_W'(1) << (TPG_W - 1);
    localparam logic [TPG_W-1:0] W_FULL  = '1;
    localparam logic [TPG_W-1:0] W_ZERO  = '0;
    localparam logic [TPG_W-1:0] W_CHK_A = alt_bits(1'b1);
    localparam logic [TPG_W-1:0] W_CHK_B = alt_bits(1'b0);
    localparam logic [TPG_W-1:0] W_SYNC  = (TPG_W'(1) << (TPG_W / 2)) - TPG_W'(1);
    localparam logic [TPG_W-1:0] W_MIXED = TPG_W'(14'h2863);

endpackage

// File: rtl/tpg_pn_gen.sv
// Module: tpg_pn_gen
// Purpose: Fibonacci shift-register pseudorandom generator with a
//   reseed pulse. Feedback is bit LEN-1 XOR bit TAP-1, shifted into
//   bit0. The register is at least OUT_W wide, so the output always
//   carries the OUT_W most recent bits.
// Assumes: TAP < LEN, OUT_W >= 1. A clear overrides a step. word_o is
//   the register value that the next edge will load.
module tpg_pn_gen #(
    parameter int LEN   = 23,
    parameter int TAP   = 18,
    parameter int OUT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    output logic [OUT_W-1:0] word_o
);

    localparam int REG_W = (LEN > OUT_W) ? LEN : OUT_W;

    logic [REG_W-1:0] sr_q;
    logic [REG_W-1:0] sr_d;
    logic             fb;

    // Next shift-register value: reseed, step or hold.
    always_comb begin
        fb = sr_q[LEN-1] ^ sr_q[TAP-1];
        if (clr_i) begin
            sr_d = '1;
        end else if (step_i) begin
            sr_d = {sr_q[REG_W-2:0], fb};
        end else begin
            sr_d = sr_q;
        end
        word_o = sr_d[OUT_W-1:0];
    end

    // Shift-register state, seeded to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '1;
        end else begin
            sr_q <= sr_d;
        end
    end

    // R7/R8: a generator seeded to all ones never reaches the all-zero lock-up state
    p_never_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);

    // R9/R10: a clear pulse leaves the register at the seed
    p_clr_seed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sr_q == '1));

endmodule

// File: rtl/tpg_seq_ctl.sv
// Module: tpg_seq_ctl
// Purpose: Tracks the toggle phase and the user-player position. A
//   restart is raised when the mode changes, or when the playback
//   control changes in user mode. The restart is held until it is
//   consumed by a valid sample.
// Assumes: the mode and control inputs are sampled every cycle. The
//   phase and count outputs are the values for the current sample.
module tpg_seq_ctl
    import tpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode_i,
    input  logic [1:0] uctl_i,
    input  logic       vld_i,
    output logic       phase_o,
    output logic [1:0] ucnt_o
);

    localparam logic [1:0] UCNT_MAX = 2'd2;

    logic [3:0] mode_q;
    logic [1:0] uctl_q;
    logic       pend_q;
    logic       phase_q;
    logic [1:0] ucnt_q;
    logic       restart;

    // Restart detection and effective position for this sample.
    always_comb begin
        restart = pend_q
                | (mode_i != mode_q)
                | ((mode_i == TM_USER) && (uctl_i != uctl_q));
        phase_o = restart ? 1'b0 : phase_q;
        ucnt_o  = restart ? 2'd0 : ucnt_q;
    end

    // Sequence state: previous controls, pending restart, phase, count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            uctl_q  <= '0;
            pend_q  <= 1'b0;
            phase_q <= 1'b0;
            ucnt_q  <= '0;
        end else begin
            mode_q <= mode_i;
            uctl_q <= uctl_i;
            if (vld_i) begin
                pend_q  <= 1'b0;
                phase_q <= ~phase_o;
                ucnt_q  <= (ucnt_o == UCNT_MAX) ? UCNT_MAX : ucnt_o + 2'd1;
            end else begin
                pend_q <= restart;
            end
        end
    end

    // R5: a sample taken on a mode change uses phase 0, so the next phase is 1
    p_restart_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && (mode_i != mode_q)) |=> phase_q);

    // R12: the player position never passes its saturation value
    p_ucnt_sat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ucnt_q <= UCNT_MAX);

endmodule

// File: rtl/tpg_user_player.sv
// Module: tpg_user_player
// Purpose: Picks the user word for the current sample from the
//   playback control (bit1 = once, bit0 = alternate), the shared
//   phase and the once-only position.
// Assumes: purely combinational. The phase and position come from
//   tpg_seq_ctl and are already restarted.
module tpg_user_player
    import tpg_pkg::*;
(
    input  logic [1:0]       uctl_i,
    input  logic             phase_i,
    input  logic [1:0]       ucnt_i,
    input  logic [TPG_W-1:0] word0_i,
    input  logic [TPG_W-1:0] word1_i,
    output logic [TPG_W-1:0] word_o
);

    logic once;
    logic alt;

    // Word selection for repeating and once-only playback.
    always_comb begin
        once = uctl_i[1];
        alt  = uctl_i[0];
        if (once) begin
            if (ucnt_i == 2'd0) begin
                word_o = word0_i;
            end else if (alt && (ucnt_i == 2'd1)) begin
                word_o = word1_i;
            end else begin
                word_o = W_ZERO;
            end
        end else if (alt) begin
            word_o = phase_i ? word1_i : word0_i;
        end else begin
            word_o = word0_i;
        end
    end

endmodule

// File: rtl/adc_test_pattern_gen.sv
// Module: adc_test_pattern_gen
// Purpose: Top level. Selects the test word or the normal data by
//   mode and registers it on each valid sample.
// Assumes: synchronous active-low reset. Unlisted mode codes pass data
//   through. Both generators step on every valid sample.
module adc_test_pattern_gen
    import tpg_pkg::*;
#(
    parameter int PN_LONG_LEN  = 23,
    parameter int PN_LONG_TAP  = 18,
    parameter int PN_SHORT_LEN = 9,
    parameter int PN_SHORT_TAP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode_i,
    input  logic [1:0]       user_ctl_i,
    input  logic [TPG_W-1:0] user_word0_i,
    input  logic [TPG_W-1:0] user_word1_i,
    input  logic             pn_long_clr_i,
    input  logic             pn_short_clr_i,
    input  logic             sample_vld_i,
    input  logic [TPG_W-1:0] data_i,
    output logic [TPG_W-1:0] data_o
);

    localparam logic [3:0] SPARE_LO = 4'd13;

    logic [TPG_W-1:0] pn_long_word;
    logic [TPG_W-1:0] pn_short_word;
    logic [TPG_W-1:0] user_word;
    logic             phase;
    logic [1:0]       ucnt;
    logic [TPG_W-1:0] data_d;
    logic [TPG_W-1:0] data_q;

    tpg_pn_gen #(
        .LEN   (PN_LONG_LEN),
        .TAP   (PN_LONG_TAP),
        .OUT_W (TPG_W)
    ) u_pn_long (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pn_long_clr_i),
        .step_i (sample_vld_i),
        .word_o (pn_long_word)
    );

    tpg_pn_gen #(
        .LEN   (PN_SHORT_LEN),
        .TAP   (PN_SHORT_TAP),
        .OUT_W (TPG_W)
    ) u_pn_short (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pn_short_clr_i),
        .step_i (sample_vld_i),
        .word_o (pn_short_word)
    );

    tpg_seq_ctl u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .uctl_i  (user_ctl_i),
        .vld_i   (sample_vld_i),
        .phase_o (phase),
        .ucnt_o  (ucnt)
    );

    tpg_user_player u_player (
        .uctl_i  (user_ctl_i),
        .phase_i (phase),
        .ucnt_i  (ucnt),
        .word0_i (user_word0_i),
        .word1_i (user_word1_i),
        .word_o  (user_word)
    );

    // Mode multiplexer: test word or normal data.
    always_comb begin
        case (mode_i)
            TM_MID:      data_d = W_MID;
            TM_POSFS:    data_d = W_FULL;
            TM_NEGFS:    data_d = W_ZERO;
            TM_CHECKER:  data_d = phase ? W_CHK_B : W_CHK_A;
            TM_PN_LONG:  data_d = pn_long_word;
            TM_PN_SHORT: data_d = pn_short_word;
            TM_WORD_TGL: data_d = phase ? W_ZERO : W_FULL;
            TM_USER:     data_d = user_word;
            TM_BIT_TGL:  data_d = W_CHK_A;
            TM_SYNC:     data_d = W_SYNC;
            TM_ONE_HIGH: data_d = W_MID;
            TM_MIXED:    data_d = W_MIXED;
            default:     data_d = data_i;
        endcase
    end

    // Output register, loaded once per valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (sample_vld_i) begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

    // R2: off mode forwards the sampled data one cycle later
    p_off_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && (mode_i == TM_OFF)) |=> (data_o == $past(data_i)));

    // R3: spare codes behave as off
    p_spare_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && (mode_i >= SPARE_LO)) |=> (data_o == $past(data_i)));

    // R4: midscale gives the MSB-only word
    p_mid_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && (mode_i == TM_MID)) |=> (data_o == W_MID));

    // R6: no valid sample, no output change
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld_i |=> $stable(data_o));

    // R9: a clear together with a sample in long-PN mode shows the seed
    p_long_clr_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && pn_long_clr_i && (mode_i == TM_PN_LONG)) |=> (data_o == W_FULL));

endmodule

// File: tb/adc_test_pattern_gen_tb.sv
`timescale 1ns/1ps
module adc_test_pattern_gen_tb;

    localparam int W = 14;
    localparam int WATCHDOG_CYC = 200000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   mode = '0;
    logic [1:0]   uctl = '0;
    logic [W-1:0] w0 = '0;
    logic [W-1:0] w1 = '0;
    logic         clr_l = 1'b0;
    logic         clr_s = 1'b0;
    logic         vld = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int           due;
        logic [W-1:0] exp;
        string        req;
    } item_t;
    item_t sb[$];

    // Reference state
    logic [3:0]   m_mode = '0;
    logic [1:0]   m_uctl = '0;
    bit           m_pend = 1'b0;
    bit           m_phase = 1'b0;
    int           m_ucnt = 0;
    logic [22:0]  m_p23 = '1;
    logic [13:0]  m_p9 = '1;
    logic [W-1:0] m_out = '0;

    always #2 clk = ~clk;

    adc_test_pattern_gen u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode),
        .user_ctl_i     (uctl),
        .user_word0_i   (w0),
        .user_word1_i   (w1),
        .pn_long_clr_i  (clr_l),
        .pn_short_clr_i (clr_s),
        .sample_vld_i   (vld),
        .data_i         (din),
        .data_o         (dout)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item whose due cycle has been reached
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (dout !== it.exp) begin
                fails++;
                $display("FAIL %s: data_o=%h expected=%h", it.req, dout, it.exp);
            end
        end
    end

    // Driver: one cycle of stimulus plus the expected word it produces
    task automatic drive(input logic [3:0] md, input logic [1:0] uc,
                         input logic [W-1:0] d, input bit v,
                         input bit cl, input bit cs, input string req);
        bit           rs;
        bit           ph;
        int           uc_n;
        logic [W-1:0] wd;
        item_t        it;
        @(negedge clk);
        mode = md; uctl = uc; din = d; vld = v; clr_l = cl; clr_s = cs;
        rs   = m_pend || (md != m_mode) || (md == 4'h8 && uc != m_uctl);
        ph   = rs ? 1'b0 : m_phase;
        uc_n = rs ? 0 : m_ucnt;
        if (cl) m_p23 = '1;
        else if (v) m_p23 = {m_p23[21:0], m_p23[22] ^ m_p23[17]};
        if (cs) m_p9 = '1;
        else if (v) m_p9 = {m_p9[12:0], m_p9[8] ^ m_p9[4]};
        case (md)
            4'h1: wd = 14'h2000;
            4'h2: wd = 14'h3FFF;
            4'h3: wd = 14'h0000;
            4'h4: wd = ph ? 14'h1555 : 14'h2AAA;
            4'h5: wd = m_p23[13:0];
            4'h6: wd = m_p9;
            4'h7: wd = ph ? 14'h0000 : 14'h3FFF;
            4'h8: begin
                if (uc[1]) wd = (uc_n == 0) ? w0 : ((uc[0] && uc_n == 1) ? w1 : 14'h0000);
                else if (uc[0]) wd = ph ? w1 : w0;
                else wd = w0;
            end
            4'h9: wd = 14'h2AAA;
            4'hA: wd = 14'h007F;
            4'hB: wd = 14'h2000;
            4'hC: wd = 14'h2863;
            default: wd = d;
        endcase
        if (v) begin
            m_out   = wd;
            m_phase = ~ph;
            m_ucnt  = (uc_n >= 2) ? 2 : uc_n + 1;
            m_pend  = 1'b0;
        end else begin
            m_pend = rs;
        end
        m_mode = md;
        m_uctl = uc;
        it.due = cyc + 1;
        it.exp = m_out;
        it.req = req;
        sb.push_back(it);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (dout !== 14'h0000) begin
            fails++;
            $display("FAIL R1: data_o=%h expected=%h", dout, 14'h0000);
        end
        w0 = 14'h1234;
        w1 = 14'h0ABC;

        // R2 pass-through, R6 hold
        drive(4'h0, 2'b00, 14'h0111, 1, 0, 0, "R2");
        drive(4'h0, 2'b00, 14'h3ABC, 1, 0, 0, "R2");
        drive(4'h0, 2'b00, 14'h0555, 0, 0, 0, "R6");
        drive(4'h0, 2'b00, 14'h1F0F, 0, 0, 0, "R6");
        drive(4'h0, 2'b00, 14'h1F0F, 1, 0, 0, "R2");
        // R3 spare codes
        drive(4'hD, 2'b00, 14'h0222, 1, 0, 0, "R3");
        drive(4'hE, 2'b00, 14'h0333, 1, 0, 0, "R3");
        drive(4'hF, 2'b00, 14'h0444, 1, 0, 0, "R3");
        // R4 fixed words
        for (int m = 1; m <= 3; m++) drive(4'(m), 2'b00, 14'h0101, 1, 0, 0, "R4");
        for (int m = 9; m <= 12; m++) begin
            drive(4'(m), 2'b00, 14'h0101, 1, 0, 0, "R4");
            drive(4'(m), 2'b00, 14'h0101, 1, 0, 0, "R4");
        end
        // R5 toggles, with idle gaps; R13 control change mid-sequence
        for (int i = 0; i < 3; i++) drive(4'h4, 2'b00, 14'h0, 1, 0, 0, "R5");
        drive(4'h4, 2'b11, 14'h0, 0, 0, 0, "R6");
        drive(4'h4, 2'b11, 14'h0, 1, 0, 0, "R13");
        drive(4'h4, 2'b01, 14'h0, 1, 0, 0, "R13");
        for (int i = 0; i < 4; i++) drive(4'h7, 2'b01, 14'h0, 1, 0, 0, "R5");
        drive(4'h4, 2'b01, 14'h0, 1, 0, 0, "R5");
        // R7 long generator
        for (int i = 0; i < 20; i++) drive(4'h5, 2'b00, 14'h0, 1, 0, 0, "R7");
        drive(4'h5, 2'b00, 14'h0, 1, 1, 0, "R9");
        for (int i = 0; i < 5; i++) drive(4'h5, 2'b00, 14'h0, 1, 0, 0, "R9");
        drive(4'h5, 2'b00, 14'h0, 0, 1, 0, "R9");
        drive(4'h5, 2'b00, 14'h0, 1, 0, 0, "R9");
        // R8 short generator, R9 left it untouched
        for (int i = 0; i < 20; i++) drive(4'h6, 2'b00, 14'h0, 1, 0, 0, "R8");
        drive(4'h6, 2'b00, 14'h0, 1, 0, 1, "R10");
        for (int i = 0; i < 4; i++) drive(4'h6, 2'b00, 14'h0, 1, 0, 0, "R10");
        drive(4'h5, 2'b00, 14'h0, 1, 0, 1, "R10");
        drive(4'h5, 2'b00, 14'h0, 1, 0, 0, "R10");
        // R11 user repeat modes
        for (int i = 0; i < 3; i++) drive(4'h8, 2'b00, 14'h0, 1, 0, 0, "R11");
        for (int i = 0; i < 5; i++) drive(4'h8, 2'b01, 14'h0, 1, 0, 0, "R11");
        // R12 once modes and re-arm
        for (int i = 0; i < 4; i++) drive(4'h8, 2'b10, 14'h0, 1, 0, 0, "R12");
        for (int i = 0; i < 5; i++) drive(4'h8, 2'b11, 14'h0, 1, 0, 0, "R12");
        drive(4'h0, 2'b11, 14'h0777, 1, 0, 0, "R12");
        drive(4'h8, 2'b11, 14'h0, 0, 0, 0, "R12");
        for (int i = 0; i < 4; i++) drive(4'h8, 2'b11, 14'h0, 1, 0, 0, "R12");
        drive(4'h0, 2'b00, 14'h0, 0, 0, 0, "R6");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: data_o=%h expected=completion", dout);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule